// File: doc/BRIEF.md
# Packed SIMD Signed Maximum Unit

This unit accepts one 32-bit three-register vector instruction word per cycle, together with the contents of its two source vectors, and returns the lane-wise maximum of those vectors one clock later. The lane width (8, 16, 32 or 64 bits) comes from a two-bit size field in the word. A single Q bit in the word picks a 64-bit or a 128-bit active vector. All lanes are compared at once, and no lane affects another.

Two mode inputs reuse the same comparators. One returns the minimum instead of the maximum. The other compares the lanes as unsigned instead of two's-complement values. With both inputs low the unit computes a signed maximum. Any word that does not carry the fixed opcode pattern, and the reserved pairing of 64-bit lanes with a 64-bit vector, raises an illegal pulse instead of producing a result. The unit has no condition-flag outputs.

Top module: `simd_lane_max`

## Requirements
- R1: A word is accepted only when bit31=0, bit29=0, bits28:24=01110, bit21=1 and bits15:10=011001. Bit30 is Q, bits23:22 are size, bits20:16 and 9:5 are the source indices and bits4:0 are Rd, so the base word is 0x0E206400. Any other strobed word gives illegal=1 and res_valid=0 in the next cycle.
- R2: The lane width is 8<<size, so size 0/1/2/3 gives 8/16/32/64-bit lanes. Lane k occupies bits k*W+W-1 down to k*W.
- R3: With Q=1 all 128 bits are processed. With Q=0 only bits 63:0 are processed, and res_data[127:64] is zero.
- R4: With sel_min=0 and sel_unsigned=0, each result lane is the larger of the two source lanes, both read as two's-complement integers.
- R5: Equal lanes return their common value. In signed mode, the most negative value against the most positive value yields the positive one.
- R6: size=3 with Q=0 is reserved. It gives illegal=1 and res_valid=0.
- R7: A legal strobed word produces res_valid=1 exactly one clock later, with res_dst equal to the word's bits4:0.
- R8: sel_min=1 returns the smaller lane value instead of the larger.
- R9: sel_unsigned=1 compares the lanes as unsigned integers, so 0x80 is larger than 0x7F in 8-bit lanes.
- R10: A cycle without a strobe gives res_valid=0 and illegal=0 next. Whenever res_valid is 0, res_data and res_dst keep their previous values.
- R11: While rst_n is low, res_valid, illegal, res_data and res_dst are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | Strobe qualifying insn and the operands |
| insn | input | 32 | Instruction word |
| src_n | input | 128 | First source vector |
| src_m | input | 128 | Second source vector |
| sel_min | input | 1 | 1: minimum, 0: maximum |
| sel_unsigned | input | 1 | 1: unsigned compare, 0: signed compare |
| res_valid | output | 1 | Result valid, one cycle after a legal strobe |
| res_data | output | 128 | Registered result vector |
| res_dst | output | 5 | Registered destination index |
| illegal | output | 1 | Pulse one cycle after a rejected strobed word |

## Verification
The assertions assume that insn, both operands and the two mode inputs are settled at the rising edge where insn_valid is high, and that they are sampled only at that edge. They also assume that the reset lasts at least one edge. The stimulus changes every input on the falling edge, holds reset low for several cycles, and then mixes legal words, words with single opcode bits flipped, the reserved size and Q pairing, and idle gaps. A behavioural lane model is compared with the outputs on every cycle.

// File: rtl/simd_max_pkg.sv
package simd_max_pkg;

   localparam int unsigned INSN_W    = 32;
   localparam int unsigned IDX_W     = 5;
   localparam int unsigned NUM_SIZES = 4;
   localparam int unsigned BASE_LANE = 8;

   // fixed opcode bits and their required values
   localparam logic [INSN_W-1:0] FIX_MASK = 32'hBF20_FC00;
   localparam logic [INSN_W-1:0] FIX_VAL  = 32'h0E20_6400;

   typedef enum logic [1:0] {
      LW_BYTE = 2'd0,
      LW_HALF = 2'd1,
      LW_WORD = 2'd2,
      LW_DBL  = 2'd3
   } lane_w_e;

   typedef struct packed {
      logic             wide;
      lane_w_e          lw;
      logic [IDX_W-1:0] rd;
   } vop_t;

endpackage

// File: rtl/simd_max_decode.sv
module simd_max_decode
   import simd_max_pkg::*;
(
   input  logic              strobe,
   input  logic [INSN_W-1:0] word,
   output vop_t              op,
   output logic              accept,
   output logic              reject
);

   logic pattern_ok;
   logic reserved;

   always_comb begin
      pattern_ok = (word & FIX_MASK) == FIX_VAL;
      op.wide    = word[30];
      op.lw      = lane_w_e'(word[23:22]);
      op.rd      = word[IDX_W-1:0];
      reserved   = (op.lw == LW_DBL) && !op.wide;
      accept     = strobe && pattern_ok && !reserved;
      reject     = strobe && !(pattern_ok && !reserved);
   end

   // R1 / R6: a strobed word is either accepted or rejected, never both
   always_comb begin
      if (strobe) begin
         p_one_outcome_r1: assert (accept ^ reject);
      end
   end

endmodule

// File: rtl/simd_seg_cmp.sv
module simd_seg_cmp #(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned LANE_W = 8
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   input  logic             want_min,
   input  logic             as_unsigned,
   output logic [VEC_W-1:0] y
);

   localparam int unsigned LANES = VEC_W / LANE_W;
   localparam logic [LANE_W-1:0] TOP_BIT = LANE_W'(1) << (LANE_W-1);

   if (LANE_W < 2 || (VEC_W % LANE_W) != 0) begin : g_bad_lane
      $error("simd_seg_cmp: lane width must divide vector width");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_W-1:0] la, lb, ka, kb;
      logic              a_above, b_above, take_a;

      always_comb begin
         la      = a[k*LANE_W +: LANE_W];
         lb      = b[k*LANE_W +: LANE_W];
         // biasing the sign bit turns a signed compare into an unsigned one
         ka      = la ^ (as_unsigned ? '0 : TOP_BIT);
         kb      = lb ^ (as_unsigned ? '0 : TOP_BIT);
         a_above = ka > kb;
         b_above = kb > ka;
         take_a  = want_min ? b_above : a_above;
      end

      assign y[k*LANE_W +: LANE_W] = take_a ? la : lb;
   end

endmodule

// File: rtl/simd_lane_sel.sv
module simd_lane_sel
   import simd_max_pkg::*;
#(
   parameter int unsigned VEC_W = 128
) (
   input  logic [VEC_W-1:0] a,
   input  logic [VEC_W-1:0] b,
   input  lane_w_e          lw,
   input  logic             wide,
   input  logic             want_min,
   input  logic             as_unsigned,
   output logic [VEC_W-1:0] y
);

   localparam int unsigned HALF_W = VEC_W / 2;

   logic [VEC_W-1:0] per_w [NUM_SIZES];
   logic [VEC_W-1:0] picked;

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
      simd_seg_cmp #(
         .VEC_W  (VEC_W),
         .LANE_W (BASE_LANE << g)
      ) u_cmp (
         .a           (a),
         .b           (b),
         .want_min    (want_min),
         .as_unsigned (as_unsigned),
         .y           (per_w[g])
      );
   end

   always_comb begin
      picked = per_w[lw];
      y      = wide ? picked : {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
   end

endmodule

// File: rtl/simd_lane_max.sv
module simd_lane_max
   import simd_max_pkg::*;
#(
   parameter int unsigned VEC_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [31:0]       insn,
   input  logic [VEC_W-1:0]  src_n,
   input  logic [VEC_W-1:0]  src_m,
   input  logic              sel_min,
   input  logic              sel_unsigned,
   output logic              res_valid,
   output logic [VEC_W-1:0]  res_data,
   output logic [4:0]        res_dst,
   output logic              illegal
);

   localparam int unsigned HALF_W = VEC_W / 2;

   if (VEC_W != 128 || INSN_W != 32 || IDX_W != 5) begin : g_bad_cfg
      $error("simd_lane_max: encoding fixes a 128-bit vector and 32-bit word");
   end

   vop_t             op;
   logic             accept;
   logic             reject;
   logic [VEC_W-1:0] lane_out;
   logic             wide_r;

   simd_max_decode u_dec (
      .strobe (insn_valid),
      .word   (insn),
      .op     (op),
      .accept (accept),
      .reject (reject)
   );

   simd_lane_sel #(.VEC_W(VEC_W)) u_sel (
      .a           (src_n),
      .b           (src_m),
      .lw          (op.lw),
      .wide        (op.wide),
      .want_min    (sel_min),
      .as_unsigned (sel_unsigned),
      .y           (lane_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         illegal   <= 1'b0;
         res_data  <= '0;
         res_dst   <= '0;
         wide_r    <= 1'b0;
      end else begin
         res_valid <= accept;
         illegal   <= reject;
         if (accept) begin
            res_data <= lane_out;
            res_dst  <= op.rd;
            wide_r   <= op.wide;
         end
      end
   end

   p_valid_xor_illegal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && illegal));

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> res_valid);

   p_dst_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (res_dst == $past(insn[4:0])));

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |=> (!res_valid && !illegal));

   p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> ($stable(res_data) && $stable(res_dst)));

   p_half_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !wide_r) |-> (res_data[VEC_W-1:HALF_W] == '0));

endmodule

// File: tb/simd_lane_max_bench.sv
module simd_lane_max_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         insn_valid = 1'b0;
   logic [31:0]  insn = '0;
   logic [127:0] src_n = '0;
   logic [127:0] src_m = '0;
   logic         sel_min = 1'b0;
   logic         sel_unsigned = 1'b0;
   logic         res_valid;
   logic [127:0] res_data;
   logic [4:0]   res_dst;
   logic         illegal;

   int checks = 0;
   int failures = 0;
   string cur_tag = "R10";
   bit done = 1'b0;

   always #5 clk = ~clk;

   simd_lane_max u_simd_lane_max (
      .clk          (clk),
      .rst_n        (rst_n),
      .insn_valid   (insn_valid),
      .insn         (insn),
      .src_n        (src_n),
      .src_m        (src_m),
      .sel_min      (sel_min),
      .sel_unsigned (sel_unsigned),
      .res_valid    (res_valid),
      .res_data     (res_data),
      .res_dst      (res_dst),
      .illegal      (illegal)
   );

   function automatic logic [31:0] mk(input logic q, input logic [1:0] sz,
                                      input logic [4:0] rm, input logic [4:0] rn,
                                      input logic [4:0] rd);
      return {1'b0, q, 1'b0, 5'b01110, sz, 1'b1, rm, 6'b011001, rn, rd};
   endfunction

   function automatic bit is_legal(input logic [31:0] w);
      return !w[31] && !w[29] && w[28:24] == 5'b01110 && w[21] &&
             w[15:10] == 6'b011001 && !(w[23:22] == 2'd3 && !w[30]);
   endfunction

   function automatic logic [127:0] ref_vec(input logic [31:0] w,
      input logic [127:0] a, input logic [127:0] b, input bit mn, input bit us);
      int wdt = 8 << w[23:22];
      int vl = w[30] ? 128 : 64;
      logic [63:0] msk = (wdt == 64) ? '1 : ((64'd1 << wdt) - 64'd1);
      logic [127:0] r = '0;
      for (int i = 0; i < vl / wdt; i++) begin
         logic [63:0] x, y, xs, ys, c;
         bit lt, gt;
         x  = 64'(a >> (i * wdt)) & msk;
         y  = 64'(b >> (i * wdt)) & msk;
         xs = 64'($signed(x << (64 - wdt)) >>> (64 - wdt));
         ys = 64'($signed(y << (64 - wdt)) >>> (64 - wdt));
         if (us) begin gt = x > y; lt = x < y; end
         else begin gt = $signed(xs) > $signed(ys); lt = $signed(xs) < $signed(ys); end
         c = mn ? (lt ? x : y) : (gt ? x : y);
         r = r | (128'(c & msk) << (i * wdt));
      end
      return r;
   endfunction

   // behavioural model, updated on the same edge as the design
   logic         m_valid = 0, m_ill = 0;
   logic [127:0] m_data = '0;
   logic [4:0]   m_dst = '0;
   string        m_tag = "R11";

   always @(posedge clk) begin
      m_tag <= cur_tag;
      if (!rst_n) begin
         m_valid <= 0; m_ill <= 0; m_data <= '0; m_dst <= '0; m_tag <= "R11";
      end else if (insn_valid && is_legal(insn)) begin
         m_valid <= 1; m_ill <= 0;
         m_data  <= ref_vec(insn, src_n, src_m, sel_min, sel_unsigned);
         m_dst   <= insn[4:0];
      end else begin
         m_valid <= 0; m_ill <= insn_valid;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (res_valid !== m_valid || illegal !== m_ill ||
             res_data !== m_data || res_dst !== m_dst) begin
            failures++;
            $display("FAIL %s: got v=%0b ill=%0b dst=%0d data=%h exp v=%0b ill=%0b dst=%0d data=%h",
                     m_tag, res_valid, illegal, res_dst, res_data,
                     m_valid, m_ill, m_dst, m_data);
         end
      end
   end

   task automatic op(input logic [31:0] w, input logic [127:0] a,
                     input logic [127:0] b, input bit mn, input bit us,
                     input string tag);
      @(negedge clk);
      insn = w; src_n = a; src_m = b; sel_min = mn; sel_unsigned = us;
      insn_valid = 1'b1; cur_tag = tag;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         insn_valid = 1'b0; cur_tag = "R10";
         src_n = {4{$urandom}}; insn = $urandom;
      end
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      repeat (4) @(negedge clk);
      // R11: reset state
      checks++;
      if (res_valid !== 0 || illegal !== 0 || res_data !== '0 || res_dst !== '0) begin
         failures++;
         $display("FAIL R11: got v=%0b ill=%0b data=%h exp zeros", res_valid, illegal, res_data);
      end
      rst_n = 1'b1;
      idle(2);
      // R4 / R2: signed max at every lane width, full vector
      for (int s = 0; s < 4; s++) op(mk(1, 2'(s), 5'd2, 5'd1, 5'(s + 3)), rnd128(), rnd128(), 0, 0, "R4");
      for (int s = 0; s < 4; s++) op(mk(1, 2'(s), 5'd0, 5'd0, 5'd9), rnd128(), rnd128(), 0, 0, "R2");
      // R3: half vector
      for (int s = 0; s < 3; s++) op(mk(0, 2'(s), 5'd4, 5'd5, 5'd6), rnd128(), rnd128(), 0, 0, "R3");
      // R5: extremes and equal lanes
      op(mk(1, 0, 0, 0, 1), {16{8'h80}}, {16{8'h7F}}, 0, 0, "R5");
      op(mk(1, 3, 0, 0, 2), {2{64'h8000_0000_0000_0000}}, {2{64'h7FFF_FFFF_FFFF_FFFF}}, 0, 0, "R5");
      op(mk(1, 1, 0, 0, 3), {8{16'hA5A5}}, {8{16'hA5A5}}, 0, 0, "R5");
      // R6: reserved pairing
      op(mk(0, 3, 1, 1, 7), rnd128(), rnd128(), 0, 0, "R6");
      idle(1);
      // R1: opcode bits flipped one at a time
      op(mk(1, 0, 0, 0, 1) | 32'h8000_0000, rnd128(), rnd128(), 0, 0, "R1");
      op(mk(1, 0, 0, 0, 1) ^ 32'h0020_0000, rnd128(), rnd128(), 0, 0, "R1");
      op(mk(1, 0, 0, 0, 1) ^ 32'h0000_0400, rnd128(), rnd128(), 0, 0, "R1");
      op(mk(1, 0, 0, 0, 1) ^ 32'h2000_0000, rnd128(), rnd128(), 0, 0, "R1");
      op(32'h0E20_6400, rnd128(), rnd128(), 0, 0, "R1");
      // R8 / R9: minimum and unsigned
      op(mk(1, 0, 0, 0, 4), {16{8'h80}}, {16{8'h7F}}, 1, 0, "R8");
      op(mk(1, 2, 0, 0, 4), rnd128(), rnd128(), 1, 0, "R8");
      op(mk(1, 0, 0, 0, 5), {16{8'h80}}, {16{8'h7F}}, 0, 1, "R9");
      op(mk(1, 1, 0, 0, 5), rnd128(), rnd128(), 1, 1, "R9");
      // R7: destination index sweep, back to back
      for (int d = 0; d < 32; d += 7) op(mk(1, 2, 0, 0, 5'(d)), rnd128(), rnd128(), 0, 0, "R7");
      idle(3);
      // mixed random traffic
      for (int i = 0; i < 300; i++) begin
         logic [31:0] w = mk($urandom_range(1), 2'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
         if ($urandom_range(7) == 0) w = w ^ (32'd1 << $urandom_range(31));
         if ($urandom_range(5) == 0) idle(1);
         op(w, rnd128(), rnd128(), $urandom_range(1), $urandom_range(1), "R4");
      end
      idle(3);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule